// File: doc/BRIEF.md
# Shared Mailbox Bank with Interrupt Aggregation

This block holds a small bank of one-word mailboxes that two agents use to pass 32-bit messages over a simple register bus. The top bit of each mailbox word is the occupancy flag: a sender posts a message by writing its payload with that bit set. A receiver hands the slot back by writing zero to the whole word, which clears the payload along with the flag.

Every mailbox produces two level conditions, FULL (flag set) and EMPTY (flag clear). Both are gathered into one raw status word. Each shared interrupt output has its own enable mask over that word. Optional per-mailbox gates can suppress a mailbox's FULL or EMPTY condition before it reaches the outputs. A read-only sizing word tells software how many units of each kind the build contains. Reads return data on the clock edge after the read strobe, and unmapped locations read as zero.

Top module: `mbox_bank`

## Requirements
- R1: A write to mailbox i at byte address 0x10*i (i < NUM_MBOX) stores all 32 bits, and a later read of that address returns them. Bit 31 is the full flag.
- R2: Writing 0x00000000 to a mailbox word clears every bit of it. That mailbox's FULL status then drops and its EMPTY status rises on the next cycle.
- R3: The raw status word at 0x304 has EMPTY of mailbox i (bit 31 clear) in bit i and FULL of mailbox i (bit 31 set) in bit 8+i. Bits of absent mailboxes and bits 31:16 read zero.
- R4: The enable mask of line n is at 0x100+4*n, in bits 15:0 with the same layout as the status word. irq_o[n] is high exactly when some gated status bit is set in that mask, and it follows mask writes on the next cycle.
- R5: An enabled EMPTY condition keeps its line high for as many cycles as the mailbox stays empty. The line drops in the cycle after a word with bit 31 set is written.
- R6: Reset (synchronous, active high) clears all mailbox words, enable masks and per-mailbox gates. All irq_o are then low, and the status word reads 0x000000FF with eight mailboxes.
- R7: The word at 0x380 reads the counts mailboxes, SS_COUNT, AS_COUNT, DB_COUNT and NUM_IRQ in 4-bit fields at bits 3:0, 7:4, 11:8, 15:12 and 19:16. Its default value is 0x00043128.
- R8: With PER_MB_IE set, bit 0 at 0x10*i+0x4 gates FULL of mailbox i and bit 0 at 0x10*i+0x8 gates EMPTY of mailbox i, on their way to the lines. Both read back at those addresses. The raw status word is not affected by them.
- R9: The word at 0x300 reads the current irq_o vector, with line n in bit n.
- R10: Reads of unmapped addresses return zero. Writes to them change no readable state, including writes to mailbox indices at or above NUM_MBOX.
- R11: bus_rdata is loaded on the clock edge where bus_rd is high and holds its value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| irq_o | output | NUM_IRQ | Shared level interrupt lines |

## Verification
A wrong flag, gate or mask bit is visible at irq_o in the cycle right after the write that caused it. It also shows in the raw status or line-state word on the next read, because the interrupt lines are combinational from stored state. Each stimulus is therefore followed by a line check and a status readback, before the next write can hide the fault. Level behaviour is checked by holding an enabled EMPTY condition for several idle cycles and then watching the line fall exactly one cycle after a posting write.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int ST_W         = 16;
    localparam int EMPTY_LSB    = 0;
    localparam int FULL_LSB     = 8;
    localparam int MAX_MBOX     = 8;
    localparam int IDX_W        = 4;

    localparam int OFS_EN_BASE  = 'h100;
    localparam int OFS_LINES    = 'h300;
    localparam int OFS_STAT     = 'h304;
    localparam int OFS_DIM      = 'h380;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_MBOX,
        RG_EN,
        RG_LINES,
        RG_STAT,
        RG_DIM
    } region_e;

    typedef enum logic [1:0] {
        MS_WORD = 2'd0,
        MS_FIE  = 2'd1,
        MS_EIE  = 2'd2,
        MS_RSVD = 2'd3
    } mb_sub_e;

    typedef struct packed {
        region_e           rg;
        logic [IDX_W-1:0]  idx;
        mb_sub_e           sub;
    } bus_dec_t;

    function automatic logic [31:0] dim_word(int nsm, int nss, int nas, int ndb, int nsi);
        return {12'b0, 4'(nsi), 4'(ndb), 4'(nas), 4'(nss), 4'(nsm)};
    endfunction

endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
    parameter int DATA_W    = 32,
    parameter bit PER_MB_IE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_word,
    input  logic              we_fie,
    input  logic              we_eie,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word_o,
    output logic              fie_o,
    output logic              eie_o,
    output logic              full_o,
    output logic              empty_o
);
    localparam int FULL_BIT = DATA_W - 1;

    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (we_word) begin
            word_q <= wdata;
        end
    end

    assign word_o  = word_q;
    assign full_o  = word_q[FULL_BIT];
    assign empty_o = ~word_q[FULL_BIT];

    generate
        if (PER_MB_IE) begin : g_gate
            logic fie_q;
            logic eie_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    fie_q <= 1'b0;
                    eie_q <= 1'b0;
                end else begin
                    if (we_fie) fie_q <= wdata[0];
                    if (we_eie) eie_q <= wdata[0];
                end
            end
            assign fie_o = fie_q;
            assign eie_o = eie_q;
        end else begin : g_nogate
            assign fie_o = 1'b1;
            assign eie_o = 1'b1;
        end
    endgenerate

    AST_WORD_LOAD: assert property (@(posedge clk) disable iff (rst)
        we_word |=> (word_o == $past(wdata)));                          // R1
    AST_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (we_word && wdata == '0) |=> (empty_o && !full_o && word_o == '0)); // R2
    AST_POST_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (we_word && wdata[FULL_BIT]) |=> !empty_o);                     // R5

endmodule

// File: rtl/mbox_irq_agg.sv
module mbox_irq_agg #(
    parameter int NUM_IRQ = 4,
    parameter int ST_W    = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_IRQ-1:0]            en_we,
    input  logic [ST_W-1:0]               en_wdata,
    input  logic [ST_W-1:0]               status_i,
    output logic [NUM_IRQ-1:0][ST_W-1:0]  en_o,
    output logic [NUM_IRQ-1:0]            irq_o
);

    generate
        for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
            logic [ST_W-1:0] mask_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    mask_q <= '0;
                end else if (en_we[n]) begin
                    mask_q <= en_wdata;
                end
            end
            assign en_o[n]  = mask_q;
            assign irq_o[n] = |(status_i & mask_q);

            AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
                (en_we[n] && en_wdata == '0) |=> !irq_o[n]);            // R4
        end
    endgenerate

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_o == '0));                                  // R6

endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
    import mbox_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NUM_MBOX  = 8,
    parameter int NUM_IRQ   = 4,
    parameter bit PER_MB_IE = 1'b1,
    parameter int SS_COUNT  = 2,
    parameter int AS_COUNT  = 1,
    parameter int DB_COUNT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_IRQ-1:0] irq_o
);
    localparam logic [31:0] DIM_VALUE =
        dim_word(NUM_MBOX, SS_COUNT, AS_COUNT, DB_COUNT, NUM_IRQ);
    localparam int EN_END = OFS_EN_BASE + 4 * NUM_IRQ;

    bus_dec_t dec;

    // Address decode of the compressed local window
    always_comb begin
        dec.rg  = RG_NONE;
        dec.idx = '0;
        dec.sub = MS_WORD;
        if (bus_addr[1:0] == 2'b00) begin
            if (bus_addr < ADDR_W'(OFS_EN_BASE)) begin
                if (int'(bus_addr[7:4]) < NUM_MBOX &&
                    mb_sub_e'(bus_addr[3:2]) != MS_RSVD) begin
                    dec.rg  = RG_MBOX;
                    dec.idx = bus_addr[7:4];
                    dec.sub = mb_sub_e'(bus_addr[3:2]);
                end
            end else if (bus_addr < ADDR_W'(EN_END)) begin
                dec.rg  = RG_EN;
                dec.idx = IDX_W'((bus_addr - ADDR_W'(OFS_EN_BASE)) >> 2);
            end else if (bus_addr == ADDR_W'(OFS_LINES)) begin
                dec.rg = RG_LINES;
            end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
                dec.rg = RG_STAT;
            end else if (bus_addr == ADDR_W'(OFS_DIM)) begin
                dec.rg = RG_DIM;
            end
        end
    end

    logic [NUM_MBOX-1:0][DATA_W-1:0] words;
    logic [NUM_MBOX-1:0] fie, eie, full, empty;
    logic [NUM_IRQ-1:0]  en_we;
    logic [NUM_IRQ-1:0][ST_W-1:0] en_val;
    logic [ST_W-1:0] status_raw, status_gated;

    generate
        for (genvar i = 0; i < NUM_MBOX; i++) begin : g_mb
            logic hit;
            assign hit = bus_we && dec.rg == RG_MBOX && dec.idx == IDX_W'(i);
            mbox_slot #(
                .DATA_W    (DATA_W),
                .PER_MB_IE (PER_MB_IE)
            ) i_slot (
                .clk     (clk),
                .rst     (rst),
                .we_word (hit && dec.sub == MS_WORD),
                .we_fie  (hit && dec.sub == MS_FIE),
                .we_eie  (hit && dec.sub == MS_EIE),
                .wdata   (bus_wdata),
                .word_o  (words[i]),
                .fie_o   (fie[i]),
                .eie_o   (eie[i]),
                .full_o  (full[i]),
                .empty_o (empty[i])
            );
        end
        for (genvar n = 0; n < NUM_IRQ; n++) begin : g_enwe
            assign en_we[n] = bus_we && dec.rg == RG_EN && dec.idx == IDX_W'(n);
        end
    endgenerate

    // Status assembly: raw view for software, gated view for the lines
    always_comb begin
        status_raw   = '0;
        status_gated = '0;
        for (int i = 0; i < NUM_MBOX; i++) begin
            status_raw[EMPTY_LSB + i]   = empty[i];
            status_raw[FULL_LSB + i]    = full[i];
            status_gated[EMPTY_LSB + i] = empty[i] & eie[i];
            status_gated[FULL_LSB + i]  = full[i] & fie[i];
        end
    end

    mbox_irq_agg #(
        .NUM_IRQ (NUM_IRQ),
        .ST_W    (ST_W)
    ) i_agg (
        .clk      (clk),
        .rst      (rst),
        .en_we    (en_we),
        .en_wdata (bus_wdata[ST_W-1:0]),
        .status_i (status_gated),
        .en_o     (en_val),
        .irq_o    (irq_o)
    );

    // Read mux and registered read data
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        rd_next = '0;
        unique case (dec.rg)
            RG_MBOX: begin
                for (int i = 0; i < NUM_MBOX; i++) begin
                    if (dec.idx == IDX_W'(i)) begin
                        case (dec.sub)
                            MS_WORD: rd_next = words[i];
                            MS_FIE:  rd_next = DATA_W'(PER_MB_IE & fie[i]);
                            MS_EIE:  rd_next = DATA_W'(PER_MB_IE & eie[i]);
                            default: rd_next = '0;
                        endcase
                    end
                end
            end
            RG_EN: begin
                for (int n = 0; n < NUM_IRQ; n++) begin
                    if (dec.idx == IDX_W'(n)) rd_next = DATA_W'(en_val[n]);
                end
            end
            RG_LINES: rd_next = DATA_W'(irq_o);
            RG_STAT:  rd_next = DATA_W'(status_raw);
            RG_DIM:   rd_next = DATA_W'(DIM_VALUE);
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_next;
        end
    end

    assign bus_rdata = rdata_q;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec.rg == RG_NONE) |=> (bus_rdata == '0));          // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));                                // R11
    AST_DIM_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec.rg == RG_DIM) |=> (bus_rdata == DATA_W'(DIM_VALUE))); // R7

endmodule

// File: tb/test_mbox_bank.sv
module test_mbox_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mbox_bank i_mbox_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // {op, addr, data}: op 0 = write, op 1 = read and compare
    localparam int NV = 16;
    localparam logic [45:0] VEC [NV] = '{
        {2'd1, 12'h304, 32'h0000_00FF},   // R6 reset status
        {2'd1, 12'h000, 32'h0000_0000},   // R6 word cleared
        {2'd1, 12'h100, 32'h0000_0000},   // R6 mask cleared
        {2'd0, 12'h010, 32'h8000_1234},   // R1 post mailbox 1
        {2'd1, 12'h010, 32'h8000_1234},   // R1
        {2'd1, 12'h304, 32'h0000_02FD},   // R3
        {2'd0, 12'h070, 32'h8ABC_DEF0},   // R1 post mailbox 7
        {2'd1, 12'h304, 32'h0000_827D},   // R3
        {2'd0, 12'h010, 32'h0000_0000},   // R2 release mailbox 1
        {2'd1, 12'h010, 32'h0000_0000},   // R2
        {2'd1, 12'h304, 32'h0000_807F},   // R2 R3
        {2'd1, 12'h380, 32'h0004_3128},   // R7
        {2'd1, 12'h0C0, 32'h0000_0000},   // R10 absent mailbox
        {2'd1, 12'h200, 32'h0000_0000},   // R10 hole
        {2'd0, 12'h090, 32'h8000_0001},   // R10 write absent mailbox
        {2'd1, 12'h304, 32'h0000_807F}    // R10 status unchanged
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R6 irq after reset", 32'(irq_o), 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][45:44] == 2'd0) begin
                wr(VEC[k][43:32], VEC[k][31:0]);
            end else begin
                rd(VEC[k][43:32], d);
                chk($sformatf("R1-table vec %0d", k), d, VEC[k][31:0]);
            end
        end

        // Mask line 1 on EMPTY of mailbox 0, gate still closed
        wr(12'h104, 32'h0000_0001);
        chk("R8 gate closed", 32'(irq_o), 32'h0);
        rd(12'h304, d);
        chk("R8 raw status ungated", d, 32'h0000_807F);
        wr(12'h008, 32'h1);
        chk("R4 line 1 on empty", 32'(irq_o), 32'h2);
        rd(12'h008, d);
        chk("R8 gate readback", d, 32'h1);
        rd(12'h300, d);
        chk("R9 line state", d, 32'h2);

        repeat (5) @(negedge clk);
        chk("R5 level held", 32'(irq_o), 32'h2);
        wr(12'h000, 32'h8000_0055);
        chk("R5 drop on post", 32'(irq_o), 32'h0);
        wr(12'h000, 32'h0000_0000);
        chk("R5 R2 rise on release", 32'(irq_o), 32'h2);

        // FULL of mailbox 7 on line 3
        wr(12'h10C, 32'h0000_8000);
        chk("R8 full gate closed", 32'(irq_o), 32'h2);
        wr(12'h074, 32'h1);
        chk("R4 line 3 on full", 32'(irq_o), 32'hA);
        wr(12'h104, 32'h0);
        chk("R4 mask cleared", 32'(irq_o), 32'h8);
        wr(12'h100, 32'h0000_8000);
        chk("R4 two lines one source", 32'(irq_o), 32'h9);
        rd(12'h10C, d);
        chk("R4 mask readback", d, 32'h0000_8000);

        // Read data hold
        rd(12'h380, d);
        @(negedge clk);
        bus_addr = 12'h070;
        @(negedge clk);
        chk("R11 rdata holds", bus_rdata, 32'h0004_3128);

        // Mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R6 irq cleared", 32'(irq_o), 32'h0);
        rd(12'h070, d);
        chk("R6 word cleared", d, 32'h0);
        rd(12'h074, d);
        chk("R6 gate cleared", d, 32'h0);
        rd(12'h10C, d);
        chk("R6 mask cleared", d, 32'h0);
        rd(12'h304, d);
        chk("R6 status empty", d, 32'h0000_00FF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule